// File: doc/BRIEF.md
# Masked Multicast Destination-Address Filter

This block screens the destination address of each received Ethernet frame against a bank of four programmable multicast filters. The six address bytes arrive one per accepted beat, first byte first, and the first byte is marked by a start-of-frame strobe. Each filter keeps a 48-bit address and a 48-bit mask. Each filter is checked as a chain of per-byte rules: a filter's running hit after byte k is its masked comparison of byte k ANDed with its hit after byte k-1.

Each filter is switched on or off only through the gate field of its byte-0 rule. A filter whose rules are being rewritten can therefore be held off while it is incomplete, and it never reports a hit until software opens the gate again. One cycle after the last address byte is taken, the block presents a per-filter hit vector and an accept flag for a single cycle.

The sequencer has four states. S_IDLE waits after reset. S_MATCH walks bytes 1 to 5. S_REPORT presents the result for one cycle. S_HOLD ignores the rest of the frame. The transitions are:
- start (any state, start-of-frame byte taken) to S_MATCH.
- last_byte (S_MATCH, byte 5 taken) to S_REPORT.
- retire (S_REPORT, no new start) to S_HOLD.
- wait (S_IDLE and S_HOLD stay put without a start).

Top module: `mcast_dest_filter`

## Requirements
- R1: After reset the filters hold these values, with byte 0 written first:
  - Filter 0: address 01:00:00:00:00:00, mask 01:00:00:00:00:00, enabled. It matches any multicast address.
  - Filter 1: address 01:80:C2:00:00:01, all mask bits set, enabled.
  - Filter 2: address zero, mask zero, disabled.
  - Filter 3: address FF:FF:FF:FF:FF:FF, all mask bits set, enabled.
- R2: A filter hits only if every address bit whose mask bit is 1 equals the received bit, in all six bytes. Mask bits of 0 are wildcards. Hit vector bit N belongs to filter N.
- R3: A frame whose byte 0 has bit 0 clear (unicast) hits no filter, whatever the filters hold.
- R4: A filter hits only if its gate is open when the result is presented. Writing 0x7F to the byte-0 gate opens it. Writing any other value closes it, whatever the filter's other rules hold.
- R5: The result valid output is high for exactly one cycle, the cycle after byte 5 is taken. The hit vector and the accept flag are zero whenever the result valid output is low.
- R6: The accept flag equals the OR of the hit vector.
- R7: A beat with both the valid and the start strobes high is byte 0 of a new frame. A partly received earlier frame is discarded.
- R8: Cycles with valid low neither advance nor disturb the byte chain. Bytes that arrive without a start strobe after byte 5, or after reset, are ignored.
- R9: Configuration writes use a kind code: 0 writes an address byte, 1 writes a mask byte, 2 writes the gate. A gate write to any byte other than 0, a write of kind 3, and a write to byte 6 or 7 change nothing.
- R10: A configuration write applies to a frame whose byte 0 arrives in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_filt | input | 2 | Filter number to write |
| cfg_kind | input | 2 | 0 address, 1 mask, 2 gate, 3 no-op |
| cfg_byte | input | 3 | Address byte number, 0 to 5 |
| cfg_data | input | 8 | Write value |
| rx_valid | input | 1 | Received byte present |
| rx_sof | input | 1 | Marks byte 0 of a frame |
| rx_data | input | 8 | Received address byte |
| res_valid | output | 1 | Result present, one cycle |
| res_hits | output | 4 | Per-filter hit vector |
| res_accept | output | 1 | Any filter hit |

## Verification
The result is registered once. The bench drives each byte on the falling edge, and the rising edge that follows takes it. The hit vector and the accept flag are due at the next falling edge after the rising edge that takes byte 5. The bench samples them there, and again one falling edge later to confirm they have dropped. Configuration writes are driven one falling edge ahead of the frame they affect, so they land on the rising edge before byte 0. For ignored bytes, the bench checks at every falling edge while those bytes stream in that no result appears.

// File: rtl/mcf_pkg.sv
`timescale 1ns/1ps
package mcf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int AW         = ADDR_BYTES * 8;
    localparam logic [7:0] GATE_ON = 8'h7F;

    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_MASK = 2'd1,
        K_GATE = 2'd2,
        K_NONE = 2'd3
    } cfg_kind_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_MATCH  = 2'd1,
        S_REPORT = 2'd2,
        S_HOLD   = 2'd3
    } seq_state_e;

    // Byte 0 sits in the top eight bits.
    function automatic logic [AW-1:0] preset_addr(input int f);
        case (f)
            0:       return 48'h01_00_00_00_00_00;
            1:       return 48'h01_80_C2_00_00_01;
            3:       return 48'hFF_FF_FF_FF_FF_FF;
            default: return '0;
        endcase
    endfunction

    function automatic logic [AW-1:0] preset_mask(input int f);
        case (f)
            0:       return 48'h01_00_00_00_00_00;
            1, 3:    return 48'hFF_FF_FF_FF_FF_FF;
            default: return '0;
        endcase
    endfunction

    function automatic logic preset_en(input int f);
        return (f == 0) || (f == 1) || (f == 3);
    endfunction
endpackage

// File: rtl/mcf_cfg_bank.sv
`timescale 1ns/1ps
module mcf_cfg_bank
    import mcf_pkg::*;
#(
    parameter int NUM_FILT = 4,
    localparam int FW = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [FW-1:0]                  cfg_filt,
    input  logic [1:0]                     cfg_kind,
    input  logic [2:0]                     cfg_byte,
    input  logic [7:0]                     cfg_data,
    output logic [NUM_FILT-1:0][AW-1:0]    addr_o,
    output logic [NUM_FILT-1:0][AW-1:0]    mask_o,
    output logic [NUM_FILT-1:0]            en_o
);
    for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
        localparam logic [FW-1:0] FID = FW'(f);
        localparam logic [AW-1:0] A0  = preset_addr(f);
        localparam logic [AW-1:0] M0  = preset_mask(f);
        localparam logic          E0  = preset_en(f);

        logic [AW-1:0] addr_q;
        logic [AW-1:0] mask_q;
        logic          en_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q <= A0;
                mask_q <= M0;
                en_q   <= E0;
            end else if (cfg_we && (cfg_filt == FID)) begin
                if ((cfg_kind == K_GATE) && (cfg_byte == 3'd0))
                    en_q <= (cfg_data == GATE_ON);
                for (int b = 0; b < ADDR_BYTES; b++) begin
                    if (cfg_byte == 3'(b)) begin
                        if (cfg_kind == K_ADDR) addr_q[AW-1-8*b -: 8] <= cfg_data;
                        if (cfg_kind == K_MASK) mask_q[AW-1-8*b -: 8] <= cfg_data;
                    end
                end
            end
        end

        assign addr_o[f] = addr_q;
        assign mask_o[f] = mask_q;
        assign en_o[f]   = en_q;
    end
endmodule

// File: rtl/mcf_byte_rule.sv
`timescale 1ns/1ps
module mcf_byte_rule
    import mcf_pkg::*;
#(
    parameter int NUM_FILT = 4
) (
    input  logic [NUM_FILT-1:0][AW-1:0] addr_i,
    input  logic [NUM_FILT-1:0][AW-1:0] mask_i,
    input  logic [2:0]                  byte_idx,
    input  logic [7:0]                  data_i,
    output logic [NUM_FILT-1:0]         match_o
);
    for (genvar f = 0; f < NUM_FILT; f++) begin : g_rule
        logic [7:0] a_sel;
        logic [7:0] m_sel;
        logic       eq;

        always_comb begin
            a_sel = '0;
            m_sel = '0;
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (byte_idx == 3'(b)) begin
                    a_sel = addr_i[f][AW-1-8*b -: 8];
                    m_sel = mask_i[f][AW-1-8*b -: 8];
                end
            end
            eq = (((data_i ^ a_sel) & m_sel) == 8'h00);
        end

        assign match_o[f] = eq;
    end
endmodule

// File: rtl/mcf_seq.sv
`timescale 1ns/1ps
module mcf_seq
    import mcf_pkg::*;
#(
    parameter int NUM_FILT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                rx_sof,
    input  logic                rx_lsb,
    input  logic [NUM_FILT-1:0] match_i,
    input  logic [NUM_FILT-1:0] en_i,
    output logic [2:0]          byte_idx,
    output logic                res_valid,
    output logic [NUM_FILT-1:0] res_hits,
    output logic                res_accept
);
    localparam logic [2:0] LAST = 3'(ADDR_BYTES - 1);

    seq_state_e          state_q, state_d;
    logic [2:0]          idx_q;
    logic [NUM_FILT-1:0] hit_q;
    logic                start;

    assign start    = rx_valid && rx_sof;
    assign byte_idx = rx_sof ? 3'd0 : idx_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: start, last_byte, retire, wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_MATCH;
            S_MATCH:  if (start) state_d = S_MATCH;
                      else if (rx_valid && (idx_q == LAST)) state_d = S_REPORT;
            S_REPORT: state_d = start ? S_MATCH : S_HOLD;
            S_HOLD:   if (start) state_d = S_MATCH;
            default:  state_d = S_IDLE;
        endcase
    end

    // Byte chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            hit_q <= '0;
        end else if (start) begin
            idx_q <= 3'd1;
            hit_q <= match_i & en_i & {NUM_FILT{rx_lsb}};
        end else if (rx_valid && (state_q == S_MATCH)) begin
            idx_q <= idx_q + 3'd1;
            hit_q <= hit_q & match_i;
        end
    end

    // Outputs
    always_comb begin
        res_valid  = (state_q == S_REPORT);
        res_hits   = res_valid ? (hit_q & en_i) : '0;
        res_accept = |res_hits;
    end
endmodule

// File: rtl/mcast_dest_filter.sv
`timescale 1ns/1ps
module mcast_dest_filter
    import mcf_pkg::*;
#(
    parameter int NUM_FILT = 4,
    localparam int FW = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [FW-1:0]       cfg_filt,
    input  logic [1:0]          cfg_kind,
    input  logic [2:0]          cfg_byte,
    input  logic [7:0]          cfg_data,
    input  logic                rx_valid,
    input  logic                rx_sof,
    input  logic [7:0]          rx_data,
    output logic                res_valid,
    output logic [NUM_FILT-1:0] res_hits,
    output logic                res_accept
);
    logic [NUM_FILT-1:0][AW-1:0] filt_addr;
    logic [NUM_FILT-1:0][AW-1:0] filt_mask;
    logic [NUM_FILT-1:0]         filt_en;
    logic [NUM_FILT-1:0]         byte_match;
    logic [2:0]                  cur_idx;

    mcf_cfg_bank #(.NUM_FILT(NUM_FILT)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_filt(cfg_filt),
        .cfg_kind(cfg_kind), .cfg_byte(cfg_byte), .cfg_data(cfg_data),
        .addr_o(filt_addr), .mask_o(filt_mask), .en_o(filt_en)
    );

    mcf_byte_rule #(.NUM_FILT(NUM_FILT)) u_rule (
        .addr_i(filt_addr), .mask_i(filt_mask), .byte_idx(cur_idx),
        .data_i(rx_data), .match_o(byte_match)
    );

    mcf_seq #(.NUM_FILT(NUM_FILT)) u_seq (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_lsb(rx_data[0]), .match_i(byte_match), .en_i(filt_en),
        .byte_idx(cur_idx), .res_valid(res_valid), .res_hits(res_hits),
        .res_accept(res_accept)
    );
endmodule

// File: rtl/mcf_checker.sv
`timescale 1ns/1ps
module mcf_checker #(
    parameter int NUM_FILT = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rx_valid,
    input logic                rx_sof,
    input logic [7:0]          rx_data,
    input logic                res_valid,
    input logic [NUM_FILT-1:0] res_hits,
    input logic                res_accept,
    input logic [NUM_FILT-1:0] filt_en
);
    logic uni_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 uni_frame <= 1'b0;
        else if (rx_valid && rx_sof) uni_frame <= !rx_data[0];
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    a_r5_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_hits == '0) && !res_accept);

    a_r5_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(rx_valid));

    a_r6_accept_or: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept == (res_hits != '0));

    a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hits & ~filt_en) == '0);

    a_r3_unicast_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && uni_frame) |-> (res_hits == '0));
endmodule

bind mcast_dest_filter mcf_checker #(.NUM_FILT(NUM_FILT)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_data(rx_data), .res_valid(res_valid), .res_hits(res_hits),
    .res_accept(res_accept), .filt_en(filt_en)
);

// File: tb/sim_mcast_dest_filter.sv
`timescale 1ns/1ps
module sim_mcast_dest_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_filt = '0;
    logic [1:0] cfg_kind = '0;
    logic [2:0] cfg_byte = '0;
    logic [7:0] cfg_data = '0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic [7:0] rx_data = '0;
    logic       res_valid;
    logic [3:0] res_hits;
    logic       res_accept;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    mcast_dest_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_filt(cfg_filt),
        .cfg_kind(cfg_kind), .cfg_byte(cfg_byte), .cfg_data(cfg_data),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .res_valid(res_valid), .res_hits(res_hits), .res_accept(res_accept)
    );

    // {destination address, expected hit vector}, bit N = filter N
    localparam logic [51:0] VEC [0:7] = '{
        {48'hFFFFFFFFFFFF, 4'b1001},
        {48'h0180C2000001, 4'b0011},
        {48'h0180C2000002, 4'b0001},
        {48'h001122334455, 4'b0000},
        {48'h333300000001, 4'b0001},
        {48'hFEFFFFFFFFFF, 4'b0000},
        {48'h0180C2000000, 4'b0001},
        {48'h0380C2000001, 4'b0001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] f, input logic [1:0] k,
                             input logic [2:0] b, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_filt = f; cfg_kind = k; cfg_byte = b; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drives six bytes; optional idle beat after byte 2. Leaves the bench
    // at the falling edge where the result is due.
    task automatic send_frame(input logic [47:0] da, input bit gap);
        for (int b = 0; b < 6; b++) begin
            if (b != 0 || cfg_we) @(negedge clk);
            cfg_we   = 1'b0;
            rx_valid = 1'b1;
            rx_sof   = (b == 0);
            rx_data  = da[47-8*b -: 8];
            if (gap && b == 2) begin
                @(negedge clk);
                rx_valid = 1'b0;
                rx_sof   = 1'b0;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
    endtask

    task automatic frame_check(input string req, input logic [47:0] da,
                               input logic [3:0] exp, input bit gap);
        send_frame(da, gap);
        check({req, " valid"}, 32'(res_valid), 32'd1);
        check({req, " hits"}, 32'(res_hits), 32'(exp));
        check({req, " R6 accept"}, 32'(res_accept), 32'(exp != 4'b0));
        @(negedge clk);
        check({req, " R5 one cycle"}, 32'(res_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state: outputs quiet
        check("R1 reset valid", 32'(res_valid), 32'd0);
        check("R5 reset hits", 32'(res_hits), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: bytes without a start strobe after reset are ignored
        for (int i = 0; i < 8; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'hFF;
            @(negedge clk);
            check("R8 no start after reset", 32'(res_valid), 32'd0);
        end
        rx_valid = 1'b0;

        // Vector table: R1 presets, R2 masking, R3 unicast
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            frame_check((VEC[i][3:0] == 4'b0) ? "R3 vec" : "R1 R2 vec",
                        VEC[i][51:4], VEC[i][3:0], 1'b0);
        end

        // R8: gaps within a frame
        @(negedge clk);
        frame_check("R8 gap", 48'h0180C2000001, 4'b0011, 1'b1);

        // R8: bytes after byte 5 without a start are ignored
        @(negedge clk);
        send_frame(48'hFFFFFFFFFFFF, 1'b0);
        check("R5 pre-extra valid", 32'(res_valid), 32'd1);
        for (int i = 0; i < 7; i++) begin
            rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'hFF;
            @(negedge clk);
            check("R8 extra bytes", 32'(res_valid), 32'd0);
        end
        rx_valid = 1'b0;

        // R7: restart drops a partial frame
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'hFF;
        @(negedge clk); rx_sof = 1'b0;
        @(negedge clk);
        frame_check("R7 restart", 48'h0180C2000001, 4'b0011, 1'b0);

        // R4: half-programmed filter 2 stays off
        cfg_write(2'd2, 2'd2, 3'd0, 8'h00);
        cfg_write(2'd2, 2'd0, 3'd0, 8'h01);
        cfg_write(2'd2, 2'd0, 3'd1, 8'h00);
        cfg_write(2'd2, 2'd0, 3'd2, 8'h5E);
        frame_check("R4 half programmed", 48'h01005E123456, 4'b0001, 1'b0);
        cfg_write(2'd2, 2'd1, 3'd0, 8'hFF);
        cfg_write(2'd2, 2'd1, 3'd1, 8'hFF);
        cfg_write(2'd2, 2'd1, 3'd2, 8'hFF);
        cfg_write(2'd2, 2'd1, 3'd3, 8'h80);
        // R10: gate write lands just before byte 0
        @(negedge clk);
        cfg_we = 1'b1; cfg_filt = 2'd2; cfg_kind = 2'd2; cfg_byte = 3'd0; cfg_data = 8'h7F;
        frame_check("R10 R2 programmed", 48'h01005E123456, 4'b0101, 1'b0);
        frame_check("R2 masked bit", 48'h01005E923456, 4'b0001, 1'b0);
        frame_check("R3 unicast filter 2", 48'h00005E123456, 4'b0000, 1'b0);

        // R4: gate values on filter 3
        cfg_write(2'd3, 2'd2, 3'd0, 8'h00);
        frame_check("R4 gate 00", 48'hFFFFFFFFFFFF, 4'b0001, 1'b0);
        cfg_write(2'd3, 2'd2, 3'd0, 8'h7E);
        frame_check("R4 gate 7E", 48'hFFFFFFFFFFFF, 4'b0001, 1'b0);
        cfg_write(2'd3, 2'd2, 3'd0, 8'h7F);
        frame_check("R4 gate 7F", 48'hFFFFFFFFFFFF, 4'b1001, 1'b0);

        // R9: ignored writes
        cfg_write(2'd3, 2'd2, 3'd1, 8'h00);
        frame_check("R9 gate byte 1", 48'hFFFFFFFFFFFF, 4'b1001, 1'b0);
        cfg_write(2'd1, 2'd3, 3'd0, 8'h00);
        frame_check("R9 kind 3", 48'h0180C2000001, 4'b0011, 1'b0);
        cfg_write(2'd1, 2'd1, 3'd6, 8'h00);
        cfg_write(2'd1, 2'd0, 3'd7, 8'h00);
        frame_check("R9 byte 6 7", 48'h0180C2000001, 4'b0011, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule